// File: doc/BRIEF.md
# Sixteen-pin GPIO bank with per-pin interrupt detection

This block serves one bank of general-purpose pins. Software reaches it through a small synchronous register port. Writes are captured on the rising clock edge when `reg_we` is high. Reads are combinational from `reg_addr`. The port covers the following:

- driving output values and output enables;
- sampling the synchronised pin levels;
- choosing, per pin, between edge and level interrupt detection and its polarity;
- masking pins;
- reading and clearing sticky interrupt flags.

A single `irq` output tells the interrupt controller that at least one unmasked flag is pending.

Every pin input passes through a two-flop synchroniser. An edge is detected by comparing the synchronised level with its value one clock earlier. A qualifying event sets the pin's sticky flag whether or not the pin is masked. The mask only gates `irq`. In level mode the flag is set again on every clock while the level stays active.

Output bits can be changed one at a time through dedicated set and clear addresses, so a single-pin update never disturbs its neighbours.

Top module: `gpio_irq_bank`

Register addresses (word addresses on `reg_addr`):

| Address | Register | Access | Reset value |
|---|---|---|---|
| 0 | output values | read/write | 0x0000 |
| 1 | output enables | read/write | 0x0000 |
| 2 | synchronised pin levels | read only | — |
| 3 | detection mode | read/write | 0x0000 |
| 4 | edge polarity | read/write | 0x0000 |
| 5 | level polarity | read/write | 0xFFFF |
| 6 | mask | read/write | 0xFFFF |
| 7 | sticky flags | read / write-to-clear | 0x0000 |
| 8 | output set | write only | — |
| 9 | output clear | write only | — |

## Requirements
- R1: After reset the registers hold the reset values in the table above, and `irq` is 0. Unused addresses 10–15 read 0.
- R2: `pin_out` equals the output-value register. `pin_oe` equals the output-enable register. Both change only on a write to address 0, 1, 8 or 9.
- R3: A write to address 8 sets the output bits that are 1 in the write data. A write to address 9 clears them. All other output bits keep their value.
- R4: Address 2 returns `pin_in` delayed by two clocks. The value becomes visible after the second rising edge following a pin change.
- R5: A pin with mode bit 1 uses edge detection. With polarity bit 1 a rising edge sets its flag; with polarity bit 0 a falling edge does. The opposite edge has no effect. The flag is readable after the third rising edge following the pin change.
- R6: A pin with mode bit 0 uses level detection. Level-polarity bit 1 means active-high and 0 means active-low. While the level is active the flag is set on every clock.
- R7: A flag is set by its event regardless of the mask. `irq` is 1 exactly when some flag is set whose mask bit is 0.
- R8: A write to address 7 ANDs the flags with the write data. Writing 0 clears every flag.
- R9: When a flag write and a new event for the same pin fall in the same cycle, the flag ends up set.
- R10: Writes to address 2 and to unused addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_addr | input | 4 | register address |
| reg_wdata | input | 16 | write data |
| reg_we | input | 1 | write enable |
| reg_rdata | output | 16 | read data for `reg_addr` |
| pin_in | input | 16 | raw pin inputs, asynchronous |
| pin_out | output | 16 | output values to the pads |
| pin_oe | output | 16 | output enables to the pads |
| irq | output | 1 | bank interrupt |

## Verification
The assertions assume that `reg_we`, `reg_addr` and `reg_wdata` are clean and stable around each rising edge. They also assume that `pin_in` may change at any time, since the properties watch only the synchronised detection result, never the raw pins. The stimulus drives every register signal and every pin change half a period away from the active edge. It changes pins only while no register write is in flight, so each flag update can be attributed to a single cause.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int N  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [N-1:0]  reg_wdata,
  input  logic          reg_we,
  output logic [N-1:0]  reg_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic          irq
);
  localparam logic [AW-1:0] A_OUT  = AW'(0);
  localparam logic [AW-1:0] A_OE   = AW'(1);
  localparam logic [AW-1:0] A_PIN  = AW'(2);
  localparam logic [AW-1:0] A_MODE = AW'(3);
  localparam logic [AW-1:0] A_RISE = AW'(4);
  localparam logic [AW-1:0] A_HIGH = AW'(5);
  localparam logic [AW-1:0] A_MASK = AW'(6);
  localparam logic [AW-1:0] A_FLAG = AW'(7);
  localparam logic [AW-1:0] A_SET  = AW'(8);
  localparam logic [AW-1:0] A_CLR  = AW'(9);
  localparam logic [N-1:0]  ONES   = {N{1'b1}};

  logic [N-1:0] out_q, oe_q, mode_q, rise_q, high_q, mask_q, flags_q;
  logic [N-1:0] sync1_q, sync2_q, prev_q;
  logic [N-1:0] rise_ev, fall_ev, edge_ev, lvl_ev, evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end

  assign rise_ev = sync2_q & ~prev_q;
  assign fall_ev = ~sync2_q & prev_q;
  assign edge_ev = (rise_ev & rise_q) | (fall_ev & ~rise_q);
  assign lvl_ev  = ~(sync2_q ^ high_q);
  assign evt     = (mode_q & edge_ev) | (~mode_q & lvl_ev);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_q  <= '0;
      oe_q   <= '0;
      mode_q <= '0;
      rise_q <= '0;
      high_q <= ONES;
      mask_q <= ONES;
    end else if (reg_we) begin
      case (reg_addr)
        A_OUT:   out_q  <= reg_wdata;
        A_OE:    oe_q   <= reg_wdata;
        A_MODE:  mode_q <= reg_wdata;
        A_RISE:  rise_q <= reg_wdata;
        A_HIGH:  high_q <= reg_wdata;
        A_MASK:  mask_q <= reg_wdata;
        A_SET:   out_q  <= out_q | reg_wdata;
        A_CLR:   out_q  <= out_q & ~reg_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      flags_q <= '0;
    else if (reg_we && reg_addr == A_FLAG)
      flags_q <= (flags_q & reg_wdata) | evt;
    else
      flags_q <= flags_q | evt;

  always_comb
    case (reg_addr)
      A_OUT:   reg_rdata = out_q;
      A_OE:    reg_rdata = oe_q;
      A_PIN:   reg_rdata = sync2_q;
      A_MODE:  reg_rdata = mode_q;
      A_RISE:  reg_rdata = rise_q;
      A_HIGH:  reg_rdata = high_q;
      A_MASK:  reg_rdata = mask_q;
      A_FLAG:  reg_rdata = flags_q;
      default: reg_rdata = '0;
    endcase

  assign pin_out = out_q;
  assign pin_oe  = oe_q;
  assign irq     = |(flags_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int N  = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [N-1:0]  reg_wdata,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  pin_oe,
  input logic [N-1:0]  flags,
  input logic [N-1:0]  evt
);
  localparam logic [AW-1:0] A_PIN  = AW'(2);
  localparam logic [AW-1:0] A_FLAG = AW'(7);
  localparam logic [AW-1:0] A_SET  = AW'(8);

  a_r2_pads_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(pin_out) && $stable(pin_oe)));

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SET) |=>
      ((pin_out & $past(reg_wdata)) == $past(reg_wdata)));

  a_r3_set_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SET) |=>
      ((pin_out & ~$past(reg_wdata)) == ($past(pin_out) & ~$past(reg_wdata))));

  a_r9_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));

  a_r8_write_ands: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_FLAG) |=>
      ((flags & ~$past(evt)) == ($past(flags) & $past(reg_wdata) & ~$past(evt))));

  a_r7_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_FLAG) |=>
      ((flags & ~$past(flags) & ~$past(evt)) == '0));

  a_r10_pin_addr_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_PIN) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N(N), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .flags(flags_q), .evt(evt)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [39:0] VEC [10] = '{
    {4'd0,  16'hA5A5, 4'd0, 16'hA5A5},  // R2
    {4'd1,  16'h00FF, 4'd1, 16'h00FF},  // R2
    {4'd3,  16'h0F0F, 4'd3, 16'h0F0F},
    {4'd4,  16'h1234, 4'd4, 16'h1234},
    {4'd5,  16'h8001, 4'd5, 16'h8001},
    {4'd6,  16'h0000, 4'd6, 16'h0000},
    {4'd8,  16'h0A00, 4'd0, 16'hAFA5},  // R3 set
    {4'd9,  16'h0005, 4'd0, 16'hAFA0},  // R3 clear
    {4'd2,  16'hFFFF, 4'd0, 16'hAFA0},  // R10
    {4'd15, 16'h1234, 4'd3, 16'h0F0F}   // R10
  };

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 out", 4'd0, 16'h0000);
    rd_chk("R1 oe", 4'd1, 16'h0000);
    rd_chk("R1 mode", 4'd3, 16'h0000);
    rd_chk("R1 rise", 4'd4, 16'h0000);
    rd_chk("R1 high", 4'd5, 16'hFFFF);
    rd_chk("R1 mask", 4'd6, 16'hFFFF);
    rd_chk("R1 flags", 4'd7, 16'h0000);
    rd_chk("R1 unused", 4'd12, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][39:36], VEC[i][35:20]);
      rd_chk("R2/R3/R10 table", VEC[i][19:16], VEC[i][15:0]);
    end
    chk("R2 pin_out", pin_out, 16'hAFA0);
    chk("R2 pin_oe", pin_oe, 16'h00FF);

    wr(4'd3, 16'h0000);
    wr(4'd5, 16'hFFFF);
    wr(4'd4, 16'h0000);
    wr(4'd6, 16'hFFFF);
    wr(4'd7, 16'h0000);
    rd_chk("R8 clear all", 4'd7, 16'h0000);

    // R4 synchroniser latency
    pins(16'h0003);
    rd_chk("R4 one clock", 4'd2, 16'h0000);
    rd_chk("R4 two clocks", 4'd2, 16'h0003);

    // edge setup: low byte rising, high byte falling
    wr(4'd3, 16'hFFFF);
    wr(4'd4, 16'h00FF);
    wr(4'd6, 16'h0000);
    wr(4'd7, 16'h0000);
    rd_chk("R8 clear", 4'd7, 16'h0000);
    chk("R7 irq idle", {15'd0, irq}, 16'd0);

    pins(16'h0007);
    @(negedge clk);
    rd_chk("R5 rise not yet", 4'd7, 16'h0000);
    rd_chk("R5 rise flag", 4'd7, 16'h0004);
    chk("R7 irq unmasked", {15'd0, irq}, 16'd1);
    wr(4'd7, 16'h0000);
    rd_chk("R8 cleared", 4'd7, 16'h0000);
    chk("R7 irq drops", {15'd0, irq}, 16'd0);

    pins(16'h0107);
    repeat (3) @(negedge clk);
    rd_chk("R5 wrong edge bit8", 4'd7, 16'h0000);
    pins(16'h0007);
    repeat (2) @(negedge clk);
    rd_chk("R5 fall flag", 4'd7, 16'h0100);
    wr(4'd7, 16'h0000);
    pins(16'h0003);
    repeat (3) @(negedge clk);
    rd_chk("R5 wrong edge bit2", 4'd7, 16'h0000);

    // R7 masked event still flags
    wr(4'd6, 16'hFFFF);
    pins(16'h0007);
    repeat (2) @(negedge clk);
    rd_chk("R7 masked flag", 4'd7, 16'h0004);
    chk("R7 masked irq", {15'd0, irq}, 16'd0);
    wr(4'd6, 16'hFFFB);
    chk("R7 unmask irq", {15'd0, irq}, 16'd1);

    // R8 partial clear
    wr(4'd7, 16'h0000);
    wr(4'd4, 16'h0000);
    pins(16'h0000);
    repeat (2) @(negedge clk);
    rd_chk("R5 three falls", 4'd7, 16'h0007);
    wr(4'd7, 16'h0005);
    rd_chk("R8 and keep", 4'd7, 16'h0005);
    wr(4'd7, 16'h0000);
    rd_chk("R8 zero", 4'd7, 16'h0000);

    // R6 level active-high, R9 event beats clear
    wr(4'd3, 16'h0000);
    wr(4'd5, 16'hFFFF);
    wr(4'd6, 16'hFFEF);
    pins(16'h0010);
    repeat (2) @(negedge clk);
    rd_chk("R6 high flag", 4'd7, 16'h0010);
    wr(4'd7, 16'h0000);
    rd_chk("R9 event wins", 4'd7, 16'h0010);
    chk("R6 irq level", {15'd0, irq}, 16'd1);
    pins(16'h0000);
    repeat (3) @(negedge clk);
    wr(4'd7, 16'h0000);
    rd_chk("R6 inactive clears", 4'd7, 16'h0000);

    // R6 active-low on bit5
    wr(4'd5, 16'hFFDF);
    rd_chk("R6 low flag", 4'd7, 16'h0020);
    pins(16'h0020);
    repeat (3) @(negedge clk);
    wr(4'd7, 16'h0000);
    rd_chk("R6 low released", 4'd7, 16'h0000);
    chk("R2 pads unchanged", pin_out, 16'hAFA0);

    summary();
  end
endmodule